// File: doc/BRIEF.md
# Lane Register Exchange Network

This block lets a group of 32 parallel lanes read each other's 32-bit register values in one step, without going through memory. On a cycle marked valid, every lane presents a value. A single set of shared controls then picks, for each lane, the lane it reads from. The controls are an operation code, one operand and a segment width. The result is registered, so the exchanged values appear one clock later.

The lanes can be split into independent segments whose size is a power of two. Every operation is confined to its own segment. Four addressing modes are available:
- broadcast from a fixed position within each segment;
- a non-wrapping shift toward higher lanes;
- a non-wrapping shift toward lower lanes;
- a bitwise-XOR butterfly.

A participation mask excludes lanes from the exchange. A lane keeps its own value when its mask bit is clear, when its computed source is outside the segment, or when its source lane is excluded by the mask.

Top module: `lane_shuffle`

## Requirements
- R1: While reset is asserted, and after it is released, `out_valid_o` is 0 and every bit of `data_o` is 0 until the first valid request.
- R2: `out_valid_o` equals `in_valid_i` one clock later. The results of a valid request appear in `data_o` at that same edge. Lane i occupies bits [i*32 +: 32] of both data buses.
- R3: When `in_valid_i` is low, `data_o` holds its previous value, whatever the other inputs do.
- R4: With `op_i` = 0 (indexed), each lane reads the lane at position (`operand_i` mod width) inside its own segment. For example, with width 16 and operand 3, lanes 0–15 read lane 3 and lanes 16–31 read lane 19.
- R5: With `op_i` = 1 (up), each lane reads the lane `operand_i` positions below it. The lowest `operand_i` lanes of each segment keep their own value, so the shift does not wrap.
- R6: With `op_i` = 2 (down), each lane reads the lane `operand_i` positions above it. The top `operand_i` lanes of each segment keep their own value.
- R7: With `op_i` = 3 (xor), each lane reads the lane whose index is its own index XOR `operand_i`. If that lane lies outside the caller's segment, the caller keeps its own value.
- R8: `width_i` gives the segment size in lanes. A value that is not a power of two between 2 and 32 is handled as 32.
- R9: A lane whose `mask_i` bit is 0 outputs its own input unchanged.
- R10: A participating lane whose computed source lane has a 0 `mask_i` bit outputs its own input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid_i | input | 1 | Request valid |
| op_i | input | 2 | 0 indexed, 1 up, 2 down, 3 xor |
| operand_i | input | 5 | Source position, shift distance or XOR lane mask |
| width_i | input | 6 | Segment width in lanes |
| mask_i | input | 32 | Participation mask, one bit per lane |
| data_i | input | 1024 | Packed lane values |
| out_valid_o | output | 1 | Result valid |
| data_o | output | 1024 | Packed exchanged values |

## Verification
The bench uses the default parameters: 32 lanes of 32 bits. With these, every legal segment width from 2 to 32 can be exercised, along with several illegal width codes such as 0, 1, 6 and 33. It can also drive XOR masks that cross a segment boundary and shift distances at or beyond the segment size. A behavioural model that uses integer division and modulo predicts every lane. The bench compares the model with the design after each clock, over directed corner cases and a run of random requests and mask patterns.

// File: rtl/lane_shuffle.sv
module lane_shuffle #(
  parameter int LANES = 32,
  parameter int DW    = 32,
  localparam int LW   = $clog2(LANES),
  localparam int WW   = LW + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid_i,
  input  logic [1:0]          op_i,
  input  logic [LW-1:0]       operand_i,
  input  logic [WW-1:0]       width_i,
  input  logic [LANES-1:0]    mask_i,
  input  logic [LANES*DW-1:0] data_i,
  output logic                out_valid_o,
  output logic [LANES*DW-1:0] data_o
);

  localparam logic [1:0] OP_IDX  = 2'd0;
  localparam logic [1:0] OP_UP   = 2'd1;
  localparam logic [1:0] OP_DOWN = 2'd2;
  localparam logic [1:0] OP_XOR  = 2'd3;

  logic          width_ok;
  logic [WW-1:0] seg_w;
  logic [LW-1:0] lmask;
  logic [LANES*DW-1:0] nxt;

  assign width_ok = (width_i >= WW'(2)) && (width_i <= WW'(LANES)) &&
                    ((width_i & (width_i - WW'(1))) == '0);
  assign seg_w    = width_ok ? width_i : WW'(LANES);
  assign lmask    = LW'(seg_w - WW'(1));

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam logic [LW-1:0] ME = LW'(i);
    logic [LW-1:0] base, rel, src;
    logic [LW:0]   reach;
    logic          hit, take;

    assign base  = ME & ~lmask;
    assign rel   = ME & lmask;
    assign reach = {1'b0, rel} + {1'b0, operand_i};

    always_comb begin
      src = ME;
      hit = 1'b0;
      case (op_i)
        OP_IDX:  begin src = base | (operand_i & lmask); hit = 1'b1; end
        OP_UP:   begin src = ME - operand_i; hit = (rel >= operand_i); end
        OP_DOWN: begin src = ME + operand_i; hit = (reach <= {1'b0, lmask}); end
        default: begin src = ME ^ operand_i; hit = ((src & ~lmask) == base); end
      endcase
    end

    assign take = hit && mask_i[i] && mask_i[src];
    assign nxt[i*DW +: DW] = take ? data_i[int'(src)*DW +: DW] : data_i[i*DW +: DW];

    // R9
    masked_lane_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid_i && !mask_i[i]) |=> (data_o[i*DW +: DW] == $past(data_i[i*DW +: DW])));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid_o <= 1'b0;
      data_o      <= '0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) data_o <= nxt;
    end
  end

  // R2
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o == $past(in_valid_i) || !$past(rst_n));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid_i |=> $stable(data_o));

  // R5
  zero_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && (op_i == OP_UP || op_i == OP_DOWN) && operand_i == '0)
      |=> (data_o == $past(data_i)));

  // R7
  xor_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && op_i == OP_XOR && operand_i == '0) |=> (data_o == $past(data_i)));

endmodule

// File: tb/tb_lane_shuffle.sv
module tb_lane_shuffle;
  localparam int N = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid_i;
  logic [1:0]    op_i;
  logic [4:0]    operand_i;
  logic [5:0]    width_i;
  logic [N-1:0]  mask_i;
  logic [N*32-1:0] data_i;
  logic          out_valid_o;
  logic [N*32-1:0] data_o;

  int checks = 0, errors = 0;
  logic [31:0] din [N];
  logic [31:0] expd [N];
  logic        expv;
  bit          done = 0;

  always #5 clk = ~clk;

  lane_shuffle dut (.clk, .rst_n, .in_valid_i, .op_i, .operand_i, .width_i,
                    .mask_i, .data_i, .out_valid_o, .data_o);

  function automatic int eff_width(int w);
    if (w == 2 || w == 4 || w == 8 || w == 16 || w == 32) return w;
    return 32;
  endfunction

  function automatic logic [31:0] model_lane(int lane, int op, int opd, int w, logic [31:0] m);
    int ew = eff_width(w);
    int seg = lane / ew;
    int r = lane % ew;
    int s = -1;
    case (op)
      0: s = seg * ew + (opd % ew);
      1: if (r - opd >= 0) s = lane - opd;
      2: if (r + opd < ew) s = lane + opd;
      default: if (((lane ^ opd) / ew) == seg) s = lane ^ opd;
    endcase
    if (s < 0 || !m[lane] || !m[s]) return din[lane];
    return din[s];
  endfunction

  task automatic set_data(int kind);
    for (int i = 0; i < N; i++) begin
      case (kind)
        0: din[i] = 32'hC0DE_0000 + 32'(i);
        1: din[i] = {8'(i), 8'(~i), 8'(i * 7), 8'(i + 100)};
        default: din[i] = $urandom;
      endcase
      data_i[i*32 +: 32] = din[i];
    end
  endtask

  task automatic compare(string tag);
    int bad = -1;
    checks++;
    for (int i = 0; i < N; i++)
      if (data_o[i*32 +: 32] !== expd[i] && bad < 0) bad = i;
    if (out_valid_o !== expv) begin
      errors++;
      $display("FAIL %s valid actual %0b expected %0b", tag, out_valid_o, expv);
    end else if (bad >= 0) begin
      errors++;
      $display("FAIL %s lane %0d actual %08h expected %08h", tag, bad,
               data_o[bad*32 +: 32], expd[bad]);
    end
  endtask

  task automatic step(bit v, int op, int opd, int w, logic [31:0] m, string tag);
    @(negedge clk);
    in_valid_i = v; op_i = 2'(op); operand_i = 5'(opd); width_i = 6'(w); mask_i = m;
    if (v) for (int i = 0; i < N; i++) expd[i] = model_lane(i, op, opd, w, m);
    expv = v;
    @(posedge clk); #1;
    compare(tag);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; in_valid_i = 1; op_i = 0; operand_i = 5; width_i = 32; mask_i = '1;
    set_data(0);
    for (int i = 0; i < N; i++) expd[i] = '0;
    expv = 0;
    repeat (3) @(posedge clk);
    #1 compare("R1 reset");
    @(negedge clk); rst_n = 1; in_valid_i = 0;
    @(posedge clk); #1 compare("R1 after reset");

    step(1, 0, 3, 16, '1, "R4 indexed w16 src3");
    step(1, 0, 3, 16, '1, "R2 back-to-back");
    set_data(1);
    step(0, 3, 7, 4, 32'h0, "R3 idle hold");
    step(0, 1, 2, 8, '1, "R3 idle hold again");
    step(1, 0, 29, 8, '1, "R4 operand mod width");
    step(1, 0, 1, 2, '1, "R4 w2");
    step(1, 1, 1, 32, '1, "R5 up w32 d1");
    step(1, 1, 3, 8, '1, "R5 up w8 d3");
    step(1, 1, 9, 8, '1, "R5 up beyond segment");
    step(1, 2, 1, 4, '1, "R6 down w4 d1");
    step(1, 2, 31, 32, '1, "R6 down d31");
    step(1, 3, 1, 32, '1, "R7 xor 1");
    step(1, 3, 16, 8, '1, "R7 xor out of segment");
    step(1, 3, 5, 8, '1, "R7 xor in segment");
    step(1, 0, 2, 6, '1, "R8 width 6 as 32");
    step(1, 1, 4, 0, '1, "R8 width 0 as 32");
    step(1, 2, 3, 1, '1, "R8 width 1 as 32");
    step(1, 0, 7, 33, '1, "R8 width 33 as 32");
    step(1, 2, 2, 16, 32'h5555_5555, "R9 half mask");
    step(1, 0, 0, 32, 32'hFFFF_FFFE, "R10 source masked");
    step(1, 3, 31, 32, 32'h0000_FFFF, "R10 xor source masked");
    step(1, 1, 1, 32, 32'h0, "R9 empty mask");
    for (int k = 0; k < 300; k++) begin
      int ws[7] = '{2, 4, 8, 16, 32, 0, 12};
      if (k % 5 == 0) set_data(2);
      step(($urandom % 4) != 0, $urandom % 4, $urandom % 32, ws[$urandom % 7],
           (k % 3 == 0) ? 32'hFFFF_FFFF : $urandom, "R2 random");
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule